// File: doc/BRIEF.md
# RAID-5 Small Write Sequencer

This block sits between a logical block write port and a single physical disk command port of a five-column parity array. For each logical write it works out the stripe holding the block, the column that stores the block and the column that stores that stripe's parity. The parity column shifts by one position from stripe to stripe. It then runs the read-modify-write sequence that keeps the parity correct while the other three data units of the stripe stay untouched.

The sequence is two reads and then two writes, issued one at a time. First the old data unit is read, then the old parity unit. Next the new data is written. Last comes the new parity, which is the XOR of the old data, the new data and the old parity. A command stays on the port until the disk side returns a one-cycle completion pulse. Both read words are captured in registers in the cycle of their completion pulse, so the disk side may change the read bus at any later time. A new logical write is taken only while the sequencer is idle. A one-cycle pulse marks the end of each logical write.

Top module: `raid5_rmw_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o and wr_done_o are 0.
- R2: A request is taken at a clock edge where req_valid_i and req_ready_o are both 1. While a sequence is in progress, req_valid_i has no effect on the commands issued.
- R3: The stripe is lba / 4, and cmd_stripe_o carries it on every command of the sequence. The parity column is 4 - (stripe mod 5). For example, lba 7 gives stripe 1 and parity column 3, lba 16 gives parity column 0, and lba 20 gives stripe 5 and parity column 4.
- R4: With idx = lba mod 4, the data column is idx when idx is below the parity column and idx + 1 otherwise. For example, lba 7 maps to column 4 and lba 16 maps to column 1.
- R5: One logical write issues exactly four commands, in this order: read data column (cmd_write_o = 0), read parity column (cmd_write_o = 0), write data column (cmd_write_o = 1), write parity column (cmd_write_o = 1).
- R6: A command holds cmd_valid_o high and keeps all of its fields stable until cmd_done_i is sampled high. The next command appears in the cycle after that.
- R7: The parity write carries old data XOR new data XOR old parity. The two old words are the read words returned with the first and second completion pulses.
- R8: Read data is sampled only in the cycle in which cmd_done_i is high. Values on cmd_rdata_i in other cycles do not affect the result.
- R9: wr_done_o is high for exactly one cycle, the cycle after the completion of the parity write. In that cycle req_ready_o is 1 and cmd_valid_o is 0.
- R10: The data write carries the word that came with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Logical write request |
| req_lba_i | input | LBA_W | Logical block number |
| req_data_i | input | DATA_W | New data word |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| cmd_valid_o | output | 1 | Physical command pending |
| cmd_disk_o | output | DISK_W | Target disk column |
| cmd_stripe_o | output | LBA_W | Stripe number on that disk |
| cmd_write_o | output | 1 | 1 = write, 0 = read |
| cmd_wdata_o | output | DATA_W | Write data |
| cmd_done_i | input | 1 | Completion pulse for the pending command |
| cmd_rdata_i | input | DATA_W | Read data, valid with cmd_done_i |
| wr_done_o | output | 1 | Logical write finished |

## Verification
The embedded properties take for granted that cmd_done_i pulses for a single cycle and only while a command is pending. The bench's disk responder meets this. It waits zero to three cycles and then raises the pulse for one cycle, only while cmd_valid_o is high. In all other cycles it drives the inverted word on the read bus, so that a read captured in the wrong cycle corrupts the parity. The bench also raises a second request during a running sequence and drops it before the final completion, so no legal hand-off is disturbed.

// File: rtl/raid5_rmw_pkg.sv
package raid5_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_DATA = 3'd1,
    ST_RD_PAR  = 3'd2,
    ST_WR_DATA = 3'd3,
    ST_WR_PAR  = 3'd4
  } step_e;
endpackage

// File: rtl/raid5_addr_map.sv
module raid5_addr_map #(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 16,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic [LBA_W-1:0]  lba_i,
  output logic [LBA_W-1:0]  stripe_o,
  output logic [DISK_W-1:0] data_col_o,
  output logic [DISK_W-1:0] par_col_o
);
  localparam int DATA_UNITS = NUM_DISKS - 1;
  localparam logic [LBA_W-1:0] DU_L   = LBA_W'(DATA_UNITS);
  localparam logic [LBA_W-1:0] ND_L   = LBA_W'(NUM_DISKS);
  localparam logic [DISK_W-1:0] LAST  = DISK_W'(NUM_DISKS - 1);

  logic [LBA_W-1:0]  idx_w, rot_w;
  logic [DISK_W-1:0] idx_c;

  always_comb begin
    stripe_o   = lba_i / DU_L;
    idx_w      = lba_i % DU_L;
    rot_w      = stripe_o % ND_L;
    idx_c      = idx_w[DISK_W-1:0];
    // parity walks left one column per stripe
    par_col_o  = LAST - rot_w[DISK_W-1:0];
    // data units skip over the parity column
    data_col_o = (idx_c >= par_col_o) ? idx_c + DISK_W'(1) : idx_c;
  end
endmodule

// File: rtl/raid5_parity_acc.sv
module raid5_parity_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_data_i,
  input  logic              cap_par_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] new_data_i,
  output logic [DATA_W-1:0] parity_o
);
  logic [DATA_W-1:0] old_data_q, old_par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_data_q <= '0;
      old_par_q  <= '0;
    end else begin
      if (cap_data_i) old_data_q <= rdata_i;
      if (cap_par_i)  old_par_q  <= rdata_i;
    end
  end

  assign parity_o = old_data_q ^ new_data_i ^ old_par_q;

  a_r8_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_data_i && cap_par_i));
endmodule

// File: rtl/raid5_step_ctrl.sv
module raid5_step_ctrl
  import raid5_rmw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_valid_i,
  input  logic  cmd_done_i,
  output step_e step_o,
  output logic  accept_o,
  output logic  cap_data_o,
  output logic  cap_par_o,
  output logic  wr_done_o
);
  step_e step_q, step_d;
  logic  done_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:    if (req_valid_i) step_d = ST_RD_DATA;
      ST_RD_DATA: if (cmd_done_i)  step_d = ST_RD_PAR;
      ST_RD_PAR:  if (cmd_done_i)  step_d = ST_WR_DATA;
      ST_WR_DATA: if (cmd_done_i)  step_d = ST_WR_PAR;
      ST_WR_PAR:  if (cmd_done_i)  step_d = ST_IDLE;
      default:                     step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_WR_PAR) && cmd_done_i;
    end
  end

  assign step_o     = step_q;
  assign accept_o   = (step_q == ST_IDLE) && req_valid_i;
  assign cap_data_o = (step_q == ST_RD_DATA) && cmd_done_i;
  assign cap_par_o  = (step_q == ST_RD_PAR) && cmd_done_i;
  assign wr_done_o  = done_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);
  a_r9_done_after_par: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> $past(step_q) == ST_WR_PAR && step_q == ST_IDLE);
endmodule

// File: rtl/raid5_rmw_seq.sv
module raid5_rmw_seq
  import raid5_rmw_pkg::*;
#(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 16,
  parameter int DATA_W    = 32,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [LBA_W-1:0]  req_lba_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              cmd_valid_o,
  output logic [DISK_W-1:0] cmd_disk_o,
  output logic [LBA_W-1:0]  cmd_stripe_o,
  output logic              cmd_write_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              cmd_done_i,
  input  logic [DATA_W-1:0] cmd_rdata_i,
  output logic              wr_done_o
);
  step_e             step;
  logic              accept, cap_data, cap_par;
  logic [LBA_W-1:0]  map_stripe;
  logic [DISK_W-1:0] map_dcol, map_pcol;
  logic [LBA_W-1:0]  stripe_q;
  logic [DISK_W-1:0] dcol_q, pcol_q;
  logic [DATA_W-1:0] new_q, parity;

  raid5_addr_map #(.NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W)) u_map (
    .lba_i      (req_lba_i),
    .stripe_o   (map_stripe),
    .data_col_o (map_dcol),
    .par_col_o  (map_pcol)
  );

  raid5_step_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .cmd_done_i  (cmd_done_i),
    .step_o      (step),
    .accept_o    (accept),
    .cap_data_o  (cap_data),
    .cap_par_o   (cap_par),
    .wr_done_o   (wr_done_o)
  );

  raid5_parity_acc #(.DATA_W(DATA_W)) u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_data_i (cap_data),
    .cap_par_i  (cap_par),
    .rdata_i    (cmd_rdata_i),
    .new_data_i (new_q),
    .parity_o   (parity)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stripe_q <= '0;
      dcol_q   <= '0;
      pcol_q   <= '0;
      new_q    <= '0;
    end else if (accept) begin
      stripe_q <= map_stripe;
      dcol_q   <= map_dcol;
      pcol_q   <= map_pcol;
      new_q    <= req_data_i;
    end
  end

  always_comb begin
    req_ready_o  = (step == ST_IDLE);
    cmd_valid_o  = (step != ST_IDLE);
    cmd_stripe_o = stripe_q;
    cmd_disk_o   = dcol_q;
    cmd_write_o  = 1'b0;
    cmd_wdata_o  = '0;
    unique case (step)
      ST_RD_PAR:  cmd_disk_o = pcol_q;
      ST_WR_DATA: begin cmd_write_o = 1'b1; cmd_wdata_o = new_q; end
      ST_WR_PAR:  begin cmd_disk_o = pcol_q; cmd_write_o = 1'b1; cmd_wdata_o = parity; end
      default: ;
    endcase
  end

  a_r6_cmd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_disk_o) &&
      $stable(cmd_stripe_o) && $stable(cmd_write_o) && $stable(cmd_wdata_o));
  a_r5_first_is_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> !cmd_write_o);
  a_r5_write_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && $rose(cmd_write_o) |-> $past(cmd_done_i));
  a_r4_cols_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> dcol_q != pcol_q && int'(dcol_q) < NUM_DISKS && int'(pcol_q) < NUM_DISKS);
  a_r2_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> $stable(stripe_q) && $stable(new_q));
endmodule

// File: tb/raid5_rmw_seq_tb.sv
module raid5_rmw_seq_tb;
  localparam int LBA_W = 16, DATA_W = 32, DISK_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, cmd_done = 1'b0;
  logic [LBA_W-1:0] req_lba = '0;
  logic [DATA_W-1:0] req_data = '0, cmd_rdata = '0;
  logic req_ready, cmd_valid, cmd_write, wr_done;
  logic [DISK_W-1:0] cmd_disk;
  logic [LBA_W-1:0] cmd_stripe;
  logic [DATA_W-1:0] cmd_wdata;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] disk_mem [int];

  always #2 clk = ~clk;

  raid5_rmw_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_lba_i(req_lba),
    .req_data_i(req_data), .req_ready_o(req_ready), .cmd_valid_o(cmd_valid),
    .cmd_disk_o(cmd_disk), .cmd_stripe_o(cmd_stripe), .cmd_write_o(cmd_write),
    .cmd_wdata_o(cmd_wdata), .cmd_done_i(cmd_done), .cmd_rdata_i(cmd_rdata),
    .wr_done_o(wr_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_rd(input int disk, input int stripe);
    int key = disk * 65536 + stripe;
    if (disk_mem.exists(key)) return disk_mem[key];
    return 32'h9E37_79B9 * (key + 1) ^ 32'h5A5A_0F0F;
  endfunction

  // reference model of the four commands for one logical write
  task automatic do_write(input int lba, input logic [DATA_W-1:0] nd, input bit spurious);
    int stripe, idx, pcol, dcol;
    int exp_disk [4];
    bit exp_wr [4];
    logic [DATA_W-1:0] exp_wd [4];
    logic [DATA_W-1:0] old_d, old_p;
    stripe = lba / 4;
    idx    = lba % 4;
    pcol   = 4 - (stripe % 5);
    dcol   = (idx < pcol) ? idx : idx + 1;
    old_d  = mem_rd(dcol, stripe);
    old_p  = mem_rd(pcol, stripe);
    exp_disk = '{dcol, pcol, dcol, pcol};
    exp_wr   = '{1'b0, 1'b0, 1'b1, 1'b1};
    exp_wd   = '{32'h0, 32'h0, nd, old_d ^ nd ^ old_p};

    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_lba = LBA_W'(lba); req_data = nd;
    @(negedge clk);
    req_valid = 1'b0; req_lba = '0; req_data = ~nd;
    for (int s = 0; s < 4; s++) begin
      int dly = $urandom_range(0, 3);
      if (spurious && s == 1) begin
        req_valid = 1'b1; req_lba = LBA_W'(lba + 9); req_data = 32'hDEAD_BEEF;
      end
      if (spurious && s == 3) req_valid = 1'b0;
      for (int w = 0; w <= dly; w++) begin
        chk(cmd_valid === 1'b1 && req_ready === 1'b0, "R6 command pending", cmd_valid, 1);
        chk(cmd_disk === DISK_W'(exp_disk[s]), "R3/R4 disk column", cmd_disk, exp_disk[s]);
        chk(cmd_stripe === LBA_W'(stripe), "R3 stripe", cmd_stripe, stripe);
        chk(cmd_write === exp_wr[s], "R5 order read/write", cmd_write, exp_wr[s]);
        if (s == 2) chk(cmd_wdata === exp_wd[s], "R10 data write word", cmd_wdata, exp_wd[s]);
        if (s == 3) chk(cmd_wdata === exp_wd[s], "R7 parity word", cmd_wdata, exp_wd[s]);
        if (w < dly) @(negedge clk);
      end
      cmd_done = 1'b1;
      cmd_rdata = (s == 0) ? old_d : (s == 1) ? old_p : 32'h1234_5678;
      if (s >= 2) disk_mem[exp_disk[s] * 65536 + stripe] = exp_wd[s];
      @(negedge clk);
      cmd_done = 1'b0;
      cmd_rdata = ~cmd_rdata; // R8: junk outside the done cycle
    end
    chk(wr_done === 1'b1, "R9 done pulse", wr_done, 1);
    chk(req_ready === 1'b1 && cmd_valid === 1'b0, "R9 idle with done", {req_ready, cmd_valid}, 2);
    @(negedge clk);
    chk(wr_done === 1'b0, "R9 done single cycle", wr_done, 0);
  endtask

  task automatic map_chk(input int lba, input int exp_p, input int exp_d);
    @(negedge clk);
    req_valid = 1'b1; req_lba = LBA_W'(lba); req_data = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_disk === DISK_W'(exp_d), "R4 fixed data column", cmd_disk, exp_d);
    chk(cmd_stripe === LBA_W'(lba / 4), "R3 fixed stripe", cmd_stripe, lba / 4);
    cmd_done = 1'b1; cmd_rdata = mem_rd(exp_d, lba / 4);
    @(negedge clk);
    chk(cmd_disk === DISK_W'(exp_p), "R3 fixed parity column", cmd_disk, exp_p);
    cmd_rdata = mem_rd(exp_p, lba / 4);
    repeat (3) @(negedge clk);
    cmd_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    chk(cmd_valid === 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
    chk(wr_done === 1'b0, "R1 reset wr_done", wr_done, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_done === 1'b0 && cmd_valid === 1'b0, "R2 idle without request", cmd_valid, 0);
    // fixed mapping corner points
    map_chk(7, 3, 4);
    map_chk(16, 0, 1);
    map_chk(20, 4, 0);
    map_chk(3, 4, 3);
    // full sequences over all parity rotations
    for (int i = 0; i < 24; i++) do_write(i, 32'hA5A5_0000 + i * 32'h0101_0101, i % 3 == 0);
    do_write(7, 32'hFFFF_FFFF, 1'b1);
    do_write(7, 32'h0000_0000, 1'b0);
    do_write(65535, 32'h1357_9BDF, 1'b1);
    for (int i = 0; i < 20; i++) do_write($urandom_range(0, 400), $urandom, i[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule